// File: doc/BRIEF.md
# Serial Decimal-Point Slot Selector

This block takes a small descriptor that arrives one bit per clock on a serial line. The descriptor says where a display's decimal point sits and whether it is shown at all. The block turns the descriptor into parallel form. It then drives the decimal-point segment enable during the scan slot of the chosen digit.

The display scanner outside the block raises one of the digit-drive lines at a time. It also pulses a digit strobe once per four-bit slot. The descriptor is taken as the four serial bits ending on the strobe cycle. It comes into use from the following strobe. The segment output works as an eight-way pick over the drive lines. A register behind the pick reloads only on the strobe and keeps its value at every other clock.

Top module: `dp_slot_select`

## Requirements
- R1: While `rst_n` is low, and at the first sample after reset, `dp_seg` is 0 and the committed descriptor has its enable bit clear.
- R2: A descriptor is the four `ser_bit` values sampled in the four clocks ending with the clock where `digit_stb` is 1, taken least-significant bit first. Bits [2:0] form the position and bit 3 is the enable.
- R3: On a clock with `digit_stb` high, if the committed descriptor is enabled, `dp_seg` loads `drive_lines[position]`. Position 0 selects `drive_lines[0]`.
- R4: On a strobe clock with the committed enable bit clear, `dp_seg` loads 0 whatever `drive_lines` holds.
- R5: On clocks with `digit_stb` low, `dp_seg` keeps its value. Changes on `drive_lines` have no effect on it.
- R6: A descriptor completed on a strobe clock does not affect the `dp_seg` value loaded on that same clock. It first governs the value loaded at the next strobe.
- R7: Serial bits older than the four clocks that end on a strobe are discarded and never reach the descriptor.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock |
| rst_n | input | 1 | Synchronous reset, active low |
| ser_bit | input | 1 | Serial descriptor data, LSB first |
| digit_stb | input | 1 | High on the last bit clock of each digit slot |
| drive_lines | input | 8 | One-hot digit-drive lines from the scanner |
| dp_seg | output | 1 | Decimal-point segment enable |

## Verification
The bench sweeps all sixteen descriptors against each of the eight active drive lines. This catches a design that takes the bits in the wrong order, misplaces the enable, or is off by one in position. It also catches a design that lights the point when disabled. Directed cases toggle the drive lines between strobes to expose a segment that follows them through the hold window. A first-slot check catches a design that applies a new descriptor one slot early. A stray leading serial bit shows up a shift register that keeps more than four bits.

// File: rtl/dps_pkg.sv
// Shared constants for the decimal-point slot selector.
// Assumes the scan has at least two digit-drive lines.
package dps_pkg;
    localparam int unsigned DEF_DIGITS = 8;

    // Width of a position field able to name any of n drive lines.
    function automatic int unsigned pos_width(input int unsigned n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction
endpackage

// File: rtl/dps_shift.sv
// Serial-to-parallel stage for the descriptor.
// Shifts every clock, LSB first. On commit it captures the staged bits
// plus the current bit as a whole descriptor. Older bits fall off the end.
module dps_shift #(
    parameter int unsigned DESC_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ser_bit,
    input  logic              commit,
    output logic [DESC_W-1:0] desc_o
);
    localparam int unsigned STG_W = DESC_W - 1;

    logic [STG_W-1:0] stage_q;

    // Keep the most recent STG_W serial bits, newest at the top.
    always_ff @(posedge clk) begin
        if (!rst_n) stage_q <= '0;
        else        stage_q <= {ser_bit, stage_q[STG_W-1:1]};
    end

    // Capture a complete descriptor on the slot's final bit.
    always_ff @(posedge clk) begin
        if (!rst_n)      desc_o <= '0;
        else if (commit) desc_o <= {ser_bit, stage_q};
    end
endmodule

// File: rtl/dps_select.sv
// Eight-way (DIGITS-way) pick of one drive line, gated by the enable bit.
// Purely combinational. Assumes pos is below DIGITS.
module dps_select #(
    parameter int unsigned DIGITS = 8,
    parameter int unsigned POS_W  = 3
) (
    input  logic [DIGITS-1:0] drive_lines,
    input  logic [POS_W-1:0]  pos,
    input  logic              en,
    output logic              sel
);
    logic [DIGITS-1:0] hit;

    // Decode the position into one match term per drive line.
    for (genvar g = 0; g < DIGITS; g++) begin : g_term
        assign hit[g] = (pos == POS_W'(g)) && drive_lines[g];
    end

    // Merge the terms and apply the enable.
    always_comb sel = en && (|hit);
endmodule

// File: rtl/dps_hold.sv
// Output register: loads on the strobe, recirculates otherwise.
module dps_hold (
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    input  logic d,
    output logic q
);
    // Reload on strobe, hold between strobes.
    always_ff @(posedge clk) begin
        if (!rst_n)    q <= 1'b0;
        else if (load) q <= d;
    end
endmodule

// File: rtl/dp_slot_select.sv
// Decimal-point slot selector top.
// Receives a serial descriptor made of a position and an enable bit.
// Lights the decimal-point segment during the slot of the chosen drive line.
// Assumes digit_stb marks the last bit of every descriptor slot and
// drive_lines is one-hot or zero.
module dp_slot_select #(
    parameter int unsigned DIGITS = dps_pkg::DEF_DIGITS
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ser_bit,
    input  logic              digit_stb,
    input  logic [DIGITS-1:0] drive_lines,
    output logic              dp_seg
);
    localparam int unsigned POS_W  = dps_pkg::pos_width(DIGITS);
    localparam int unsigned DESC_W = POS_W + 1;

    logic [DESC_W-1:0] desc_q;
    logic              pick;

    dps_shift #(.DESC_W(DESC_W)) u_shift (
        .clk     (clk),
        .rst_n   (rst_n),
        .ser_bit (ser_bit),
        .commit  (digit_stb),
        .desc_o  (desc_q)
    );

    dps_select #(.DIGITS(DIGITS), .POS_W(POS_W)) u_select (
        .drive_lines (drive_lines),
        .pos         (desc_q[POS_W-1:0]),
        .en          (desc_q[DESC_W-1]),
        .sel         (pick)
    );

    dps_hold u_hold (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (digit_stb),
        .d     (pick),
        .q     (dp_seg)
    );
endmodule

// File: rtl/dp_slot_select_chk.sv
// Checker for dp_slot_select, attached by bind below.
module dp_slot_select_chk #(
    parameter int unsigned DIGITS = 8,
    parameter int unsigned POS_W  = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic              digit_stb,
    input logic [DIGITS-1:0] drive_lines,
    input logic              dp_seg,
    input logic [POS_W:0]    desc
);
    // R1: reset clears the output and the enable bit.
    assert_reset_clear_R1: assert property (@(posedge clk)
        !rst_n |=> (!dp_seg && !desc[POS_W]));

    // R3: an enabled strobe loads the drive line named by the position.
    assert_pick_line_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (digit_stb && desc[POS_W]) |=> (dp_seg == $past(drive_lines[desc[POS_W-1:0]])));

    // R4: a disabled descriptor keeps the segment dark.
    assert_disabled_dark_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (digit_stb && !desc[POS_W]) |=> !dp_seg);

    // R5: the segment holds between strobes.
    assert_hold_between_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !digit_stb |=> $stable(dp_seg));

    // R6: the committed descriptor changes only on a strobe.
    assert_commit_on_strobe_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !digit_stb |=> $stable(desc));
endmodule

bind dp_slot_select dp_slot_select_chk #(.DIGITS(DIGITS), .POS_W(POS_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .digit_stb   (digit_stb),
    .drive_lines (drive_lines),
    .dp_seg      (dp_seg),
    .desc        (desc_q)
);

// File: tb/dp_slot_select_tb.sv
module dp_slot_select_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ser_bit = 1'b0;
    logic       digit_stb = 1'b0;
    logic [7:0] drive_lines = '0;
    logic       dp_seg;

    int checks = 0;
    int failures = 0;
    logic [3:0] committed = 4'h0;   // bench model of the committed descriptor
    bit done = 0;

    always #2 clk = ~clk;

    dp_slot_select u_dut (
        .clk(clk), .rst_n(rst_n), .ser_bit(ser_bit),
        .digit_stb(digit_stb), .drive_lines(drive_lines), .dp_seg(dp_seg)
    );

    task automatic check(input string req, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0b expected=%0b", req, act, exp);
        end
    endtask

    // Send one slot LSB first, strobe on the 4th bit; sample after the strobe edge.
    task automatic slot(input logic [3:0] d, input logic [7:0] dl, output logic exp);
        exp = committed[3] & dl[committed[2:0]];
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            ser_bit = d[i];
            drive_lines = dl;
            digit_stb = (i == 3);
        end
        @(negedge clk);
        digit_stb = 1'b0;
        committed = d;
    endtask

    initial begin
        logic e;
        repeat (3) @(negedge clk);
        check("R1 reset", dp_seg, 1'b0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 after reset", dp_seg, 1'b0);

        // R2 R3 R4: all descriptors against every active line.
        for (int d = 0; d < 16; d++) begin
            slot(4'(d), 8'h00, e);
            for (int p = 0; p < 8; p++) begin
                slot(4'(d), 8'(1 << p), e);
                check(d[3] ? "R3 pick" : "R4 disabled", dp_seg, e);
            end
        end

        // R6: new descriptor does not act on its own strobe.
        slot(4'b1010, 8'h04, e);            // pos 2 enabled committed
        slot(4'b1101, 8'h04, e);            // new desc pos 5 arrives
        check("R6 old desc on same strobe", dp_seg, 1'b1);
        slot(4'b1101, 8'h04, e);
        check("R6 new desc next strobe", dp_seg, 1'b0);
        slot(4'b1101, 8'h20, e);
        check("R6 new desc active line", dp_seg, 1'b1);

        // R5: drive-line changes between strobes are ignored.
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            drive_lines = (i == 1) ? 8'hFF : 8'h00;
            check("R5 hold high", dp_seg, 1'b1);
        end
        slot(4'b0101, 8'h20, e);            // commit disabled
        slot(4'b0101, 8'h20, e);
        check("R5 setup dark", dp_seg, 1'b0);
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            drive_lines = 8'hFF;
            check("R5 hold low", dp_seg, 1'b0);
        end

        // R7: a stray bit before the slot is discarded.
        @(negedge clk);
        ser_bit = 1'b1;
        slot(4'b0001, 8'h02, e);            // would be 0b0011 if stray kept
        slot(4'b0001, 8'h02, e);
        check("R7 stray bit dropped disabled", dp_seg, 1'b0);
        @(negedge clk);
        ser_bit = 1'b0;
        slot(4'b1011, 8'h08, e);            // pos 3 enabled; stray 0 leading
        slot(4'b1011, 8'h08, e);
        check("R7 stray zero dropped", dp_seg, 1'b1);
        slot(4'b1000, 8'h01, e);
        check("R2 position zero line", dp_seg, 1'b0);
        slot(4'b1000, 8'h01, e);
        check("R2 position zero selects line 0", dp_seg, 1'b1);

        done = 1;
    end

    initial begin
        for (int c = 0; c < 20000 && !done; c++) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=hung expected=done");
        end
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule